// File: doc/BRIEF.md
# Dual-Pair Oldest-First Issue Arbiter

This block chooses which instructions leave a 20-slot integer issue queue in each cycle. Every occupied slot carries a pair bit that is fixed when the slot is written: 0 sends it to the upper pair of execution subclusters, 1 sends it to the lower pair. Once its operands are ready, a slot raises request bits for the subclusters of its pair that can execute it.

Two independent arbiters each fill the two subcluster slots of one pair. The first subcluster of a pair (U0 or L0) goes to the oldest slot requesting it. The second subcluster (U1 or L1) goes to the oldest remaining slot that requests it. The block therefore issues up to four instructions per cycle. Age is held in a pairwise older-than matrix that is updated when a slot is written. A granted slot empties at the next clock edge, and a flush empties every slot.

Top module: `dual_pair_issue_arb`

## Requirements
- R1: After reset no slot is occupied, and all four grant vectors are zero whatever the requests are.
- R2: When `ins_valid_i` is high at a clock edge, slot `ins_idx_i` becomes occupied with pair bit `ins_lower_i` and is younger than every slot already occupied. The write is ignored if that slot is occupied at the edge or if `flush_i` is high.
- R3: A slot with pair bit 0 is granted only on U0/U1, and its L0/L1 requests are ignored. A slot with pair bit 1 is granted only on L0/L1, and its U0/U1 requests are ignored.
- R4: In the same cycle, the U0 grant goes to the oldest occupied upper slot requesting U0. The L0 grant goes to the oldest occupied lower slot requesting L0.
- R5: The U1 grant goes to the oldest occupied upper slot requesting U1 that did not get U0. L1 is granted by the same rule among lower slots.
- R6: Each grant vector has at most one bit set (bit k = slot k), and no slot gets two subclusters in one cycle.
- R7: A granted slot is unoccupied from the next clock edge and receives no further grants until it is written again.
- R8: `flush_i` high at a clock edge leaves every slot unoccupied.
- R9: Requests from unoccupied slots are ignored.
- R10: Grants in one pair do not depend on requests or slots of the other pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Empty every slot at the next edge |
| ins_valid_i | input | 1 | Write a slot this cycle |
| ins_idx_i | input | 5 | Slot index to write |
| ins_lower_i | input | 1 | Pair bit of the written slot (0 upper, 1 lower) |
| req_u0_i | input | 20 | Per-slot request for subcluster U0 |
| req_u1_i | input | 20 | Per-slot request for subcluster U1 |
| req_l0_i | input | 20 | Per-slot request for subcluster L0 |
| req_l1_i | input | 20 | Per-slot request for subcluster L1 |
| gnt_u0_o | output | 20 | One-hot grant for U0 |
| gnt_u1_o | output | 20 | One-hot grant for U1 |
| gnt_l0_o | output | 20 | One-hot grant for L0 |
| gnt_l1_o | output | 20 | One-hot grant for L1 |
| gnt_l1_o | output | 20 | One-hot grant for L1 |

## Verification
The bench targets the following cases and the failure each one exposes:
- A slot that requests both subclusters of its pair while being the oldest. A design that skips the masking would grant it twice, and a younger slot would lose U1 or L1.
- Slots freed and rewritten at low indices. These show whether age follows write order or index: a design that uses index priority picks the wrong winner.
- Wrong-pair requests and requests from empty slots, mixed into random traffic. A missing mask would grant a lower slot on U0 or revive a retired slot.
- A write to an already occupied slot, and flushes that land together with writes. A design that handles these wrongly would reorder ages or leave stale slots granting after a flush.

// File: rtl/issue_arb_pkg.sv
package issue_arb_pkg;
  localparam int unsigned NUM_PAIRS      = 2;
  localparam int unsigned SLOTS_PER_PAIR = 2;

  typedef enum logic {
    PAIR_UPPER = 1'b0,
    PAIR_LOWER = 1'b1
  } pair_e;
endpackage

// File: rtl/age_matrix.sv
// Slot occupancy, pair bits and pairwise age; older_q[j*N+i] = slot j older than slot i.
module age_matrix #(
  parameter int unsigned NUM_ENTRIES = 20,
  localparam int unsigned IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               flush_i,
  input  logic                               ins_valid_i,
  input  logic [IDX_W-1:0]                   ins_idx_i,
  input  logic                               ins_lower_i,
  input  logic [NUM_ENTRIES-1:0]             retire_i,
  output logic [NUM_ENTRIES-1:0]             valid_o,
  output logic [NUM_ENTRIES-1:0]             lower_o,
  output logic [NUM_ENTRIES*NUM_ENTRIES-1:0] older_o
);
  logic [NUM_ENTRIES-1:0]             valid_q, lower_q;
  logic [NUM_ENTRIES*NUM_ENTRIES-1:0] older_q;
  logic                               do_ins;

  assign do_ins = ins_valid_i && !flush_i &&
                  (int'(ins_idx_i) < int'(NUM_ENTRIES)) && !valid_q[ins_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      lower_q <= '0;
      older_q <= '0;
    end else if (flush_i) begin
      valid_q <= '0;
    end else begin
      valid_q <= valid_q & ~retire_i;
      if (do_ins) begin
        valid_q[ins_idx_i] <= 1'b1;
        lower_q[ins_idx_i] <= ins_lower_i;
        for (int j = 0; j < int'(NUM_ENTRIES); j++) begin
          older_q[j*int'(NUM_ENTRIES) + int'(ins_idx_i)] <= valid_q[j];
          older_q[int'(ins_idx_i)*int'(NUM_ENTRIES) + j] <= 1'b0;
        end
      end
    end
  end

  assign valid_o = valid_q;
  assign lower_o = lower_q;
  assign older_o = older_q;
endmodule

// File: rtl/oldest_pick.sv
// Grants the eligible slot that no other eligible slot is older than.
module oldest_pick #(
  parameter int unsigned NUM_ENTRIES = 20
) (
  input  logic [NUM_ENTRIES-1:0]             elig_i,
  input  logic [NUM_ENTRIES*NUM_ENTRIES-1:0] older_i,
  output logic [NUM_ENTRIES-1:0]             gnt_o
);
  always_comb begin
    for (int i = 0; i < int'(NUM_ENTRIES); i++) begin
      logic blocked;
      blocked = 1'b0;
      for (int j = 0; j < int'(NUM_ENTRIES); j++)
        blocked = blocked | (elig_i[j] & older_i[j*int'(NUM_ENTRIES) + i]);
      gnt_o[i] = elig_i[i] & ~blocked;
    end
  end
endmodule

// File: rtl/pair_arbiter.sv
module pair_arbiter
  import issue_arb_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 20,
  parameter pair_e       PAIR_ID     = PAIR_UPPER
) (
  input  logic [NUM_ENTRIES-1:0]                     valid_i,
  input  logic [NUM_ENTRIES-1:0]                     lower_i,
  input  logic [NUM_ENTRIES*NUM_ENTRIES-1:0]         older_i,
  input  logic [SLOTS_PER_PAIR-1:0][NUM_ENTRIES-1:0] req_i,
  output logic [SLOTS_PER_PAIR-1:0][NUM_ENTRIES-1:0] gnt_o
);
  logic [NUM_ENTRIES-1:0] mine;
  logic [SLOTS_PER_PAIR:0][NUM_ENTRIES-1:0] taken;

  assign mine     = valid_i & ((PAIR_ID == PAIR_LOWER) ? lower_i : ~lower_i);
  assign taken[0] = '0;

  // Slots filled in order; each later slot excludes entries already granted.
  for (genvar s = 0; s < int'(SLOTS_PER_PAIR); s++) begin : g_slot
    logic [NUM_ENTRIES-1:0] elig;
    assign elig = mine & req_i[s] & ~taken[s];
    oldest_pick #(.NUM_ENTRIES(NUM_ENTRIES)) u_pick (
      .elig_i (elig),
      .older_i(older_i),
      .gnt_o  (gnt_o[s])
    );
    assign taken[s+1] = taken[s] | gnt_o[s];
  end
endmodule

// File: rtl/dual_pair_issue_arb.sv
module dual_pair_issue_arb
  import issue_arb_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 20,
  localparam int unsigned IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   flush_i,
  input  logic                   ins_valid_i,
  input  logic [IDX_W-1:0]       ins_idx_i,
  input  logic                   ins_lower_i,
  input  logic [NUM_ENTRIES-1:0] req_u0_i,
  input  logic [NUM_ENTRIES-1:0] req_u1_i,
  input  logic [NUM_ENTRIES-1:0] req_l0_i,
  input  logic [NUM_ENTRIES-1:0] req_l1_i,
  output logic [NUM_ENTRIES-1:0] gnt_u0_o,
  output logic [NUM_ENTRIES-1:0] gnt_u1_o,
  output logic [NUM_ENTRIES-1:0] gnt_l0_o,
  output logic [NUM_ENTRIES-1:0] gnt_l1_o
);
  logic [NUM_ENTRIES-1:0]                                    entry_valid, entry_lower, retire;
  logic [NUM_ENTRIES*NUM_ENTRIES-1:0]                        older;
  logic [NUM_PAIRS-1:0][SLOTS_PER_PAIR-1:0][NUM_ENTRIES-1:0] req_pair, gnt_pair;

  assign req_pair[PAIR_UPPER] = {req_u1_i, req_u0_i};
  assign req_pair[PAIR_LOWER] = {req_l1_i, req_l0_i};

  age_matrix #(.NUM_ENTRIES(NUM_ENTRIES)) u_age (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .ins_valid_i(ins_valid_i),
    .ins_idx_i  (ins_idx_i),
    .ins_lower_i(ins_lower_i),
    .retire_i   (retire),
    .valid_o    (entry_valid),
    .lower_o    (entry_lower),
    .older_o    (older)
  );

  for (genvar p = 0; p < int'(NUM_PAIRS); p++) begin : g_pair
    pair_arbiter #(
      .NUM_ENTRIES(NUM_ENTRIES),
      .PAIR_ID    (pair_e'(p))
    ) u_arb (
      .valid_i(entry_valid),
      .lower_i(entry_lower),
      .older_i(older),
      .req_i  (req_pair[p]),
      .gnt_o  (gnt_pair[p])
    );
  end

  always_comb begin
    retire = '0;
    for (int p = 0; p < int'(NUM_PAIRS); p++)
      for (int s = 0; s < int'(SLOTS_PER_PAIR); s++)
        retire = retire | gnt_pair[p][s];
  end

  assign gnt_u0_o = gnt_pair[PAIR_UPPER][0];
  assign gnt_u1_o = gnt_pair[PAIR_UPPER][1];
  assign gnt_l0_o = gnt_pair[PAIR_LOWER][0];
  assign gnt_l1_o = gnt_pair[PAIR_LOWER][1];
endmodule

// File: rtl/dual_pair_issue_arb_chk.sv
module dual_pair_issue_arb_chk #(
  parameter int unsigned NUM_ENTRIES = 20
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   flush_i,
  input logic [NUM_ENTRIES-1:0] entry_valid,
  input logic [NUM_ENTRIES-1:0] entry_lower,
  input logic [NUM_ENTRIES-1:0] req_u0_i,
  input logic [NUM_ENTRIES-1:0] req_u1_i,
  input logic [NUM_ENTRIES-1:0] req_l0_i,
  input logic [NUM_ENTRIES-1:0] req_l1_i,
  input logic [NUM_ENTRIES-1:0] gnt_u0_o,
  input logic [NUM_ENTRIES-1:0] gnt_u1_o,
  input logic [NUM_ENTRIES-1:0] gnt_l0_o,
  input logic [NUM_ENTRIES-1:0] gnt_l1_o
);
  logic [NUM_ENTRIES-1:0] gnt_all;
  assign gnt_all = gnt_u0_o | gnt_u1_o | gnt_l0_o | gnt_l1_o;

  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_u0_o) && $onehot0(gnt_u1_o) && $onehot0(gnt_l0_o) && $onehot0(gnt_l1_o)); // R6
  AST_ONE_SLOT_PER_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_u0_o & gnt_u1_o) == '0) && ((gnt_l0_o & gnt_l1_o) == '0)); // R6
  AST_GNT_IN_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((gnt_u0_o | gnt_u1_o) & entry_lower) == '0) &&
    (((gnt_l0_o | gnt_l1_o) & ~entry_lower) == '0)); // R3
  AST_GNT_REQUESTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_u0_o & ~(req_u0_i & entry_valid)) == '0) && ((gnt_u1_o & ~(req_u1_i & entry_valid)) == '0) &&
    ((gnt_l0_o & ~(req_l0_i & entry_valid)) == '0) && ((gnt_l1_o & ~(req_l1_i & entry_valid)) == '0)); // R9
  AST_SLOT0_SERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(req_u0_i & entry_valid & ~entry_lower)) |-> (|gnt_u0_o)); // R4
  AST_GRANT_RETIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_all) |=> ((entry_valid & $past(gnt_all)) == '0)); // R7
  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (entry_valid == '0)); // R8
endmodule

bind dual_pair_issue_arb dual_pair_issue_arb_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .flush_i    (flush_i),
  .entry_valid(entry_valid),
  .entry_lower(entry_lower),
  .req_u0_i   (req_u0_i),
  .req_u1_i   (req_u1_i),
  .req_l0_i   (req_l0_i),
  .req_l1_i   (req_l1_i),
  .gnt_u0_o   (gnt_u0_o),
  .gnt_u1_o   (gnt_u1_o),
  .gnt_l0_o   (gnt_l0_o),
  .gnt_l1_o   (gnt_l1_o)
);

// File: tb/dual_pair_issue_arb_bench.sv
module dual_pair_issue_arb_bench;
  localparam int N = 20;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         flush_i = 1'b0;
  logic         ins_valid_i = 1'b0;
  logic [4:0]   ins_idx_i = '0;
  logic         ins_lower_i = 1'b0;
  logic [N-1:0] req_u0_i = '0, req_u1_i = '0, req_l0_i = '0, req_l1_i = '0;
  logic [N-1:0] gnt_u0_o, gnt_u1_o, gnt_l0_o, gnt_l1_o;

  dual_pair_issue_arb #(.NUM_ENTRIES(N)) u_dual_pair_issue_arb (.*);

  always #5 clk_i = ~clk_i;

  // Reference model: occupancy, pair bit, write-order stamp.
  bit          m_valid[N];
  bit          m_lower[N];
  int unsigned m_stamp[N];
  int unsigned stamp_ctr = 0;
  int          n_checks = 0, n_fail = 0;
  bit          done = 0;

  function automatic logic [N-1:0] pick(input bit lower, input logic [N-1:0] req,
                                        input logic [N-1:0] excl);
    int best = -1;
    for (int k = 0; k < N; k++)
      if (m_valid[k] && m_lower[k] == lower && req[k] && !excl[k])
        if (best < 0 || m_stamp[k] < m_stamp[best]) best = k;
    pick = '0;
    if (best >= 0) pick[best] = 1'b1;
  endfunction

  task automatic cmp(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called just after a falling edge with inputs set; checks, then advances the model.
  task automatic cycle(input string t0, input string t1);
    logic [N-1:0] eu0, eu1, el0, el1;
    bit pre_valid;
    #1;
    eu0 = pick(1'b0, req_u0_i, '0);   // R4
    eu1 = pick(1'b0, req_u1_i, eu0);  // R5
    el0 = pick(1'b1, req_l0_i, '0);   // R4
    el1 = pick(1'b1, req_l1_i, el0);  // R5
    cmp({t0, " U0"}, gnt_u0_o, eu0);
    cmp({t1, " U1"}, gnt_u1_o, eu1);
    cmp({t0, " L0"}, gnt_l0_o, el0);
    cmp({t1, " L1"}, gnt_l1_o, el1);
    pre_valid = (ins_idx_i < N) ? m_valid[ins_idx_i] : 1'b1;
    for (int k = 0; k < N; k++)
      if (eu0[k] | eu1[k] | el0[k] | el1[k]) m_valid[k] = 0;  // R7
    if (flush_i) begin
      for (int k = 0; k < N; k++) m_valid[k] = 0;              // R8
    end else if (ins_valid_i && !pre_valid) begin              // R2
      m_valid[ins_idx_i] = 1;
      m_lower[ins_idx_i] = ins_lower_i;
      m_stamp[ins_idx_i] = stamp_ctr++;
    end
    @(negedge clk_i);
  endtask

  task automatic clear_in();
    flush_i = 0; ins_valid_i = 0;
    req_u0_i = '0; req_u1_i = '0; req_l0_i = '0; req_l1_i = '0;
  endtask

  task automatic put(input int idx, input bit lower, input string tag);
    clear_in();
    ins_valid_i = 1; ins_idx_i = 5'(idx); ins_lower_i = lower;
    cycle(tag, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1_500_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    for (int k = 0; k < N; k++) begin m_valid[k] = 0; m_lower[k] = 0; m_stamp[k] = 0; end
    repeat (3) @(negedge clk_i);
    // R1: held in reset with every request raised
    req_u0_i = '1; req_u1_i = '1; req_l0_i = '1; req_l1_i = '1;
    #1;
    cmp("R1 reset U0", gnt_u0_o, '0); cmp("R1 reset U1", gnt_u1_o, '0);
    cmp("R1 reset L0", gnt_l0_o, '0); cmp("R1 reset L1", gnt_l1_o, '0);
    @(negedge clk_i);
    rst_ni = 1;
    cycle("R1", "R1");
    clear_in();

    // R2: age follows write order, not index
    put(9, 0, "R2"); put(2, 0, "R2"); put(15, 0, "R2"); put(4, 1, "R2"); put(0, 1, "R2");
    put(9, 1, "R2");  // occupied: ignored
    clear_in(); req_u0_i[2] = 1; req_u0_i[9] = 1; req_u1_i[15] = 1; req_u1_i[2] = 1;
    cycle("R2 R4", "R5");  // U0 -> 9 (older), U1 -> 2
    // R6: oldest requests both U0 and U1; U1 moves to the next
    clear_in(); req_u0_i[15] = 1; req_u1_i[15] = 1; req_l0_i[4] = 1; req_l1_i[4] = 1; req_l1_i[0] = 1;
    cycle("R6", "R6");
    // R7: retired slots no longer served; R9 empty slot ignored
    clear_in(); req_u0_i = '1; req_l0_i = '1; req_u1_i = '1; req_l1_i = '1;
    cycle("R7 R9", "R7 R9");
    // R3: wrong-pair requests ignored
    put(3, 0, "R3"); put(5, 1, "R3");
    clear_in(); req_l0_i[3] = 1; req_l1_i[3] = 1; req_u0_i[5] = 1; req_u1_i[5] = 1;
    cycle("R3", "R3");
    // R10: lower traffic does not disturb upper
    clear_in(); req_u1_i[3] = 1; req_l0_i = '1; req_l1_i = '1;
    cycle("R10", "R10");
    // R8: flush with a simultaneous write
    put(6, 0, "R8"); put(7, 1, "R8");
    clear_in(); flush_i = 1; ins_valid_i = 1; ins_idx_i = 5'd8;
    cycle("R8", "R8");
    clear_in(); req_u0_i = '1; req_u1_i = '1; req_l0_i = '1; req_l1_i = '1;
    cycle("R8", "R8");

    // Random mix: writes, requests incl. wrong pair and empty slots, rare flush
    for (int c = 0; c < 3000; c++) begin
      clear_in();
      ins_valid_i = ($urandom_range(3) != 0);
      ins_idx_i   = 5'($urandom_range(N - 1));
      ins_lower_i = 1'($urandom_range(1));
      flush_i     = ($urandom_range(99) == 0);
      req_u0_i = N'($urandom) & N'($urandom);
      req_u1_i = N'($urandom) & N'($urandom);
      req_l0_i = N'($urandom) & N'($urandom);
      req_l1_i = N'($urandom) & N'($urandom);
      cycle("R4 R6 R10", "R5 R6 R10");
    end
    finish_run();
  end
endmodule